// File: doc/BRIEF.md
# System Clock Autogating Controller

This controller decides when the chip's system clock may be stopped and brings it back safely. It watches the power state of every power domain. When autogating is enabled and each domain reports either retention or off, it closes the clock gate. It then turns the source off. With the internal oscillator in use, it drops the oscillator enable. With an external clock in bypass mode, it drops the active-high clock request to tell the outside source it may stop.

A wake request, or any domain leaving its idle state, restarts the source. The gate stays closed while a programmable setup count of slow 32 kHz ticks elapses, which gives the source time to settle. The clock is then released, divided by one or by two. The divide ratio may change only on a divided-clock boundary, so no short pulse ever leaves the block.

All pins are plain control and status levels sampled on the controller clock. There is no streamed data and so no valid/ready handshake. `tick_32k` is a one-cycle pulse, already synchronized, marking each slow-clock period. The setup count register is cleared only by the cold reset. Both resets leave the clock running with no setup wait, because reset alone already covers source settling.

Top module: `sysclk_autogate`

## Requirements
- R1: After either reset the clock gate is open, `clk_en` is high every cycle, `div2_act` is 0, and `osc_en` equals the inverse of `bypass_mode` while `clk_req` equals `bypass_mode`.
- R2: With the gate open, `autogate_en` high and every domain field of `dom_pwr` equal to 2'b01 (retention) or 2'b10 (off), the gate closes on the next clock edge.
- R3: The gate stays open if `autogate_en` is low or any domain field is 2'b00 (on) or 2'b11 (in transition).
- R4: In oscillator mode (`bypass_mode`=0), `osc_en` is low while gated and `clk_req` stays low.
- R5: In bypass mode (`bypass_mode`=1), `osc_en` stays low, and `clk_req` is low while gated and high otherwise.
- R6: While gated, a `wake_req` pulse or any domain field leaving retention/off restarts the source on the next edge, with the gate still closed. Without either, the block stays gated.
- R7: With a setup count of N, the gate opens on the edge that samples the (N+1)th `tick_32k` pulse after the restart. N=0 opens on the first tick, and the maximum count works the same way.
- R8: `setup_wr` loads `setup_val` into the setup count register. Only `cold_rst_n` clears it, to 0, and the warm `rst_n` leaves it unchanged.
- R9: With `div2_act`=1 the open clock yields `clk_en` on every second cycle, starting on the second cycle after release. With `div2_act`=0 it yields `clk_en` every cycle.
- R10: While the clock is open, `div2_act` follows `div2_sel` only on the edge right after a cycle with `clk_en` high. While gated it follows `div2_sel` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| cold_rst_n | input | 1 | Cold reset, active low; also clears setup count |
| rst_n | input | 1 | Warm reset, active low |
| dom_pwr | input | 2*N_DOM | Per-domain power state: 00 on, 01 retention, 10 off, 11 in transition |
| autogate_en | input | 1 | Autogating enable |
| bypass_mode | input | 1 | 0 internal oscillator, 1 external clock in bypass |
| div2_sel | input | 1 | Requested divide ratio: 0 by one, 1 by two |
| wake_req | input | 1 | Explicit wake request |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| setup_wr | input | 1 | Load strobe for the setup count |
| setup_val | input | CNT_W | Setup count value in 32 kHz ticks |
| osc_en | output | 1 | Internal oscillator enable |
| clk_req | output | 1 | Request to the external clock source, active high |
| clk_gate_open | output | 1 | High while the system clock is allowed through |
| clk_en | output | 1 | Per-cycle enable of the gated, divided clock |
| div2_act | output | 1 | Divide ratio currently applied |

## Verification
The bench builds the block with three domains and a 4-bit setup count. With these values the full count of 15 ticks fits in a short run, so the wait at the largest count and at zero are both checked. Three domains are enough to mix retention, off, on and in-transition fields in one vector. Cold and warm resets are issued separately to show which of them clears the loaded count.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    SG_RUN   = 2'b00,
    SG_GATED = 2'b01,
    SG_WAIT  = 2'b10
  } sg_state_t;

  localparam logic [1:0] PWR_ON    = 2'b00;
  localparam logic [1:0] PWR_RET   = 2'b01;
  localparam logic [1:0] PWR_OFF   = 2'b10;
  localparam logic [1:0] PWR_TRANS = 2'b11;
endpackage

// File: rtl/sag_idle_detect.sv
module sag_idle_detect #(
  parameter int N_DOM = 4
) (
  input  logic [2*N_DOM-1:0] dom_pwr,
  output logic               all_idle
);
  import sag_pkg::*;

  logic [N_DOM-1:0] dom_idle;

  // A domain counts as idle in retention or off only.
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic [1:0] st;
    assign st          = dom_pwr[2*d +: 2];
    assign dom_idle[d] = (st == PWR_RET) || (st == PWR_OFF);
  end

  assign all_idle = &dom_idle;
endmodule

// File: rtl/sag_setup_timer.sv
module sag_setup_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             sys_rst_n,
  input  logic             setup_wr,
  input  logic [CNT_W-1:0] setup_val,
  input  logic             load,
  input  logic             busy,
  input  logic             tick_32k,
  output logic             done
);
  logic [CNT_W-1:0] setup_q;
  logic [CNT_W-1:0] cnt_q;

  // Setup count register: survives warm reset.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n)   setup_q <= '0;
    else if (setup_wr) setup_q <= setup_val;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)                              cnt_q <= '0;
    else if (load)                               cnt_q <= setup_q;
    else if (busy && tick_32k && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = busy && tick_32k && (cnt_q == '0);

  assert_setup_hold_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !setup_wr |=> $stable(setup_q));

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (busy && !load && tick_32k && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sag_div_ctrl.sv
module sag_div_ctrl (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic open,
  input  logic div2_sel,
  output logic div2_act,
  output logic clk_en
);
  logic phase_q;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      phase_q  <= 1'b0;
      div2_act <= 1'b0;
    end else if (!open) begin
      phase_q  <= 1'b0;
      div2_act <= div2_sel;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) div2_act <= div2_sel;
    end
  end

  assign clk_en = open && (!div2_act || phase_q);

  assert_div_boundary_R10: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (open && $past(open) && (div2_act != $past(div2_act))) |-> $past(phase_q));
endmodule

// File: rtl/sysclk_autogate.sv
module sysclk_autogate #(
  parameter int N_DOM = 4,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               cold_rst_n,
  input  logic               rst_n,
  input  logic [2*N_DOM-1:0] dom_pwr,
  input  logic               autogate_en,
  input  logic               bypass_mode,
  input  logic               div2_sel,
  input  logic               wake_req,
  input  logic               tick_32k,
  input  logic               setup_wr,
  input  logic [CNT_W-1:0]   setup_val,
  output logic               osc_en,
  output logic               clk_req,
  output logic               clk_gate_open,
  output logic               clk_en,
  output logic               div2_act
);
  import sag_pkg::*;

  logic      sys_rst_n;
  logic      all_idle;
  logic      setup_done;
  logic      load;
  sg_state_t state_q, state_d;

  assign sys_rst_n = rst_n & cold_rst_n;

  sag_idle_detect #(.N_DOM(N_DOM)) u_idle (
    .dom_pwr  (dom_pwr),
    .all_idle (all_idle)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      SG_RUN:   if (autogate_en && all_idle) state_d = SG_GATED;
      SG_GATED: if (wake_req || !all_idle)   state_d = SG_WAIT;
      SG_WAIT:  if (setup_done)              state_d = SG_RUN;
      default:                               state_d = SG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) state_q <= SG_RUN;
    else            state_q <= state_d;
  end

  assign load = (state_q == SG_GATED) && (state_d == SG_WAIT);

  sag_setup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .sys_rst_n  (sys_rst_n),
    .setup_wr   (setup_wr),
    .setup_val  (setup_val),
    .load       (load),
    .busy       (state_q == SG_WAIT),
    .tick_32k   (tick_32k),
    .done       (setup_done)
  );

  // Source stays on except while gated; the mode picks which pin carries it.
  assign osc_en        = !bypass_mode && (state_q != SG_GATED);
  assign clk_req       =  bypass_mode && (state_q != SG_GATED);
  assign clk_gate_open = (state_q == SG_RUN);

  sag_div_ctrl u_div (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .open      (clk_gate_open),
    .div2_sel  (div2_sel),
    .div2_act  (div2_act),
    .clk_en    (clk_en)
  );

  assert_enter_gate_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (state_q == SG_RUN && autogate_en && all_idle) |=> (state_q == SG_GATED));

  assert_stay_open_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (state_q == SG_RUN && (!autogate_en || !all_idle)) |=> clk_gate_open);

  assert_wake_restart_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (state_q == SG_GATED && wake_req) |=> (state_q == SG_WAIT && !clk_gate_open));

  assert_open_on_tick_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(clk_gate_open) |-> $past(tick_32k));

  assert_source_off_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (state_q == SG_RUN && autogate_en && all_idle && !bypass_mode) |=> !osc_en);
endmodule

// File: tb/sysclk_autogate_bench.sv
module sysclk_autogate_bench;
  localparam int N_DOM = 3;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic cold_rst_n, rst_n;
  logic [2*N_DOM-1:0] dom_pwr;
  logic autogate_en, bypass_mode, div2_sel, wake_req, tick_32k, setup_wr;
  logic [CNT_W-1:0] setup_val;
  logic osc_en, clk_req, clk_gate_open, clk_en, div2_act;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sysclk_autogate #(.N_DOM(N_DOM), .CNT_W(CNT_W)) u_sysclk_autogate (
    .clk(clk), .cold_rst_n(cold_rst_n), .rst_n(rst_n), .dom_pwr(dom_pwr),
    .autogate_en(autogate_en), .bypass_mode(bypass_mode), .div2_sel(div2_sel),
    .wake_req(wake_req), .tick_32k(tick_32k), .setup_wr(setup_wr),
    .setup_val(setup_val), .osc_en(osc_en), .clk_req(clk_req),
    .clk_gate_open(clk_gate_open), .clk_en(clk_en), .div2_act(div2_act)
  );

  typedef struct {
    string tag;
    int g, o, r, e, d;
  } exp_t;
  exp_t q[$];

  // Domain fields: 00 on, 01 retention, 10 off, 11 in transition.
  localparam logic [5:0] ALL_IDLE = {2'b01, 2'b10, 2'b01};

  task automatic cmp(string tag, string what, int act, int expv);
    if (expv >= 0) begin
      checks++;
      if (act != expv) begin
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
    end
  endtask

  // Monitor: pops expected items and compares them after each edge.
  initial forever begin
    @(posedge clk);
    #3;
    while (q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      cmp(x.tag, "clk_gate_open", int'(clk_gate_open), x.g);
      cmp(x.tag, "osc_en", int'(osc_en), x.o);
      cmp(x.tag, "clk_req", int'(clk_req), x.r);
      cmp(x.tag, "clk_en", int'(clk_en), x.e);
      cmp(x.tag, "div2_act", int'(div2_act), x.d);
    end
  end

  // Driver: one edge, then queue what that edge must produce.
  task automatic step(string tag, int g, int o, int r, int e, int d);
    exp_t x;
    @(posedge clk);
    x.tag = tag; x.g = g; x.o = o; x.r = r; x.e = e; x.d = d;
    q.push_back(x);
    @(negedge clk);
  endtask

  task automatic tick_step(string tag, int g, int o, int r, int e, int d);
    tick_32k = 1'b1;
    step(tag, g, o, r, e, d);
    tick_32k = 1'b0;
  endtask

  task automatic load_setup(int v);
    setup_wr = 1'b1;
    setup_val = CNT_W'(v);
    @(negedge clk);
    setup_wr = 1'b0;
  endtask

  task automatic do_reset(bit cold);
    rst_n = 1'b0;
    if (cold) cold_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cold_rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit prev_en;
    bit seen;
    cold_rst_n = 1'b0; rst_n = 1'b0; dom_pwr = '0; autogate_en = 1'b0;
    bypass_mode = 1'b0; div2_sel = 1'b0; wake_req = 1'b0; tick_32k = 1'b0;
    setup_wr = 1'b0; setup_val = '0;
    repeat (3) @(negedge clk);
    do_reset(1'b1);

    // R1: running after reset, oscillator mode
    step("R1", 1, 1, 0, 1, 0);

    // R3: not all idle / enable low / transition field
    autogate_en = 1'b1; dom_pwr = {2'b01, 2'b10, 2'b00};
    step("R3 one on", 1, 1, 0, 1, 0);
    dom_pwr = {2'b11, 2'b10, 2'b01};
    step("R3 transition", 1, 1, 0, 1, 0);
    autogate_en = 1'b0; dom_pwr = ALL_IDLE;
    step("R3 disabled", 1, 1, 0, 1, 0);

    load_setup(2);

    // R2/R4: gate in oscillator mode
    autogate_en = 1'b1;
    step("R2 R4 gate", 0, 0, 0, 0, -1);
    step("R6 no wake stays", 0, 0, 0, 0, -1);
    wake_req = 1'b1; autogate_en = 1'b0;
    step("R6 wake restart", 0, 1, 0, 0, -1);
    wake_req = 1'b0;
    // R7: setup 2 needs three ticks
    tick_step("R7 tick1", 0, 1, 0, 0, -1);
    step("R7 no tick", 0, 1, 0, 0, -1);
    tick_step("R7 tick2", 0, 1, 0, 0, -1);
    tick_step("R7 tick3", 1, 1, 0, 1, 0);

    // R5: bypass mode, domain leaving idle wakes it
    bypass_mode = 1'b1;
    step("R5 run bypass", 1, 0, 1, 1, 0);
    autogate_en = 1'b1;
    step("R5 gated bypass", 0, 0, 0, 0, -1);
    dom_pwr = {2'b01, 2'b10, 2'b00}; autogate_en = 1'b0;
    step("R6 domain wake", 0, 0, 1, 0, -1);
    tick_step("R7 bypass t1", 0, 0, 1, 0, -1);
    tick_step("R7 bypass t2", 0, 0, 1, 0, -1);
    tick_step("R7 bypass t3", 1, 0, 1, 1, 0);

    // R8: warm reset keeps setup count 2
    bypass_mode = 1'b0; dom_pwr = ALL_IDLE;
    do_reset(1'b0);
    step("R1 after warm reset", 1, 1, 0, 1, 0);
    autogate_en = 1'b1;
    step("R8 gate", 0, 0, 0, 0, -1);
    wake_req = 1'b1; autogate_en = 1'b0;
    step("R8 wake", 0, 1, 0, 0, -1);
    wake_req = 1'b0;
    tick_step("R8 t1", 0, 1, 0, 0, -1);
    tick_step("R8 t2 still gated", 0, 1, 0, 0, -1);
    tick_step("R8 t3 open", 1, 1, 0, 1, 0);

    // R8/R7: cold reset clears to zero, first tick opens
    do_reset(1'b1);
    step("R1 after cold reset", 1, 1, 0, 1, 0);
    autogate_en = 1'b1;
    step("R8 cold gate", 0, 0, 0, 0, -1);
    wake_req = 1'b1; autogate_en = 1'b0;
    step("R8 cold wake", 0, 1, 0, 0, -1);
    wake_req = 1'b0;
    step("R7 zero no tick", 0, 1, 0, 0, -1);
    tick_step("R7 zero first tick", 1, 1, 0, 1, 0);

    // R7 maximum count, R9 divide by two chosen while gated
    load_setup(15);
    autogate_en = 1'b1;
    step("R7 max gate", 0, 0, 0, 0, -1);
    wake_req = 1'b1; autogate_en = 1'b0; div2_sel = 1'b1;
    step("R7 max wake", 0, 1, 0, 0, 1);
    wake_req = 1'b0;
    for (int i = 0; i < 15; i++) tick_step("R7 max waiting", 0, 1, 0, 0, 1);
    tick_step("R7 max open R9", 1, 1, 0, 0, 1);
    step("R9 div2 pulse", 1, 1, 0, 1, 1);
    step("R9 div2 gap", 1, 1, 0, 0, 1);
    step("R9 div2 pulse2", 1, 1, 0, 1, 1);

    // R10: switch back to divide by one only after a pulse
    div2_sel = 1'b0;
    prev_en = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk);
      #3;
      if (seen) cmp("R9 div1 every cycle", "clk_en", int'(clk_en), 1);
      if (!seen && div2_act == 1'b0) begin
        seen = 1'b1;
        cmp("R10 boundary", "prev clk_en", int'(prev_en), 1);
      end
      prev_en = clk_en;
    end
    cmp("R10 switched", "seen", int'(seen), 1);

    @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule